// File: doc/BRIEF.md
# Seeded Permutation Vector Generator

This block turns a size `m` and a pair of small seed integers `(a, b)` into a permutation of the values 1 to `m`. It keeps a working list that starts with the values 0 to `m-1`. At step `j`, counting from 1 to `m`, it picks one entry of that list by a modular index. It emits `m` minus the picked entry and then removes the entry, so every value comes out exactly once. Output entry `j` is the 1-based row, counted from the bottom, of the single 1 in column `j` of a square permutation matrix. That matrix is one building block of a structured low-density parity-check code, and the vector specifies it in full.

A start pulse latches `m`, `a` and `b` while the block is idle. The results then leave through a valid/ready stream that carries the step index and the value. A result is transferred on a rising clock edge where both `out_valid` and `out_ready` are high. While `out_ready` is low the block holds `out_valid`, `out_index` and `out_value` steady and makes no progress. No new result appears until the one on offer has been taken. After the last transfer, `done` rises and stays high until the next accepted start. A size of zero, or a size above the parameter `MMAX`, raises `err` and produces no output. Each step spends a fixed number of cycles in a shift-and-subtract remainder unit, then waits for the consumer.

Top module: `permvec_gen`

## Requirements
- R1: After reset, `out_valid`, `busy`, `done` and `err` are all low.
- R2: For step j, the selected index is k = (a*j + b) mod (m + 1 - j). The value for that step is m minus the entry at position k of the live list, which initially holds 0..m-1 in positions 0..m-1. After the pick, entries above k move down one place.
- R3: With m = 6, a = 5 and b = 3, the emitted values are 4, 2, 3, 1, 6, 5 in that order.
- R4: Over one run, the emitted values are each in 1..m and form a permutation of 1..m, with no value repeated.
- R5: `out_index` carries the 1-based step number. Transfers occur with index 1, 2, ..., m in order, and each index appears once.
- R6: While `out_valid` is high and `out_ready` is low, on the next cycle `out_valid` stays high and `out_index` and `out_value` are unchanged.
- R7: `done` rises after exactly m transfers, with `busy` low and `out_valid` low. It stays high until the next accepted start.
- R8: A start with m = 0 or m > MMAX sets `err`, and leaves `out_valid`, `busy` and `done` low. A later start with a valid m clears `err`.
- R9: A start pulse while `busy` is high is ignored. The running sequence continues unchanged.
- R10: m = 1 yields a single transfer of value 1 at index 1.
- R11: Sizes up to and including MMAX are accepted, with seeds up to the full SW-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run with the sizes on m_in, a_in, b_in (taken only when not busy) |
| m_in | input | VW | Vector length m |
| a_in | input | SW | Seed multiplier a |
| b_in | input | SW | Seed offset b |
| busy | output | 1 | A run is in progress |
| err | output | 1 | Last start carried an unsupported size |
| done | output | 1 | Last run finished all m transfers |
| out_valid | output | 1 | A result is on offer |
| out_ready | input | 1 | Consumer accepts the result on offer |
| out_index | output | VW | 1-based step number of the result |
| out_value | output | VW | Permutation value, 1..m |

## Verification
The bench builds the block with its defaults: MMAX = 96 and 8-bit seeds. It sweeps every size from 1 to 10 against every seed pair with a and b in 0..5. Half of these runs use a stalling consumer, so back-pressure is exercised at every step position. Because MMAX is at least 83, the same build also runs the seven documented size-83 seed pairs, a full-size m = 96 run with the largest seeds, and the rejected sizes just past the limit. Each run is compared against an arithmetic list-removal model in the bench.

// File: rtl/permvec_pkg.sv
package permvec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV_GO,
    ST_DIV_WAIT,
    ST_EMIT,
    ST_DONE
  } pv_state_t;
endpackage

// File: rtl/pv_modred.sv
// Sequential restoring remainder: rem = num mod den, one numerator bit per cycle.
module pv_modred #(
  parameter int NW = 16,
  parameter int VW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [VW-1:0] den,
  output logic          fin,
  output logic [VW-1:0] rem
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] sh;
  logic [CW-1:0] cnt;
  logic          act;
  logic [VW:0]   r2;
  logic [VW:0]   nxt;

  always_comb begin
    r2  = {rem, sh[NW-1]};
    nxt = (r2 >= {1'b0, den}) ? (r2 - {1'b0, den}) : r2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
      act <= 1'b0;
      fin <= 1'b0;
      rem <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        sh  <= num;
        rem <= '0;
        cnt <= CW'(NW);
        act <= 1'b1;
      end else if (act) begin
        rem <= nxt[VW-1:0];
        sh  <= sh << 1;
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          act <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pv_list.sv
// Working list of unused values; one-cycle removal by shifting the upper part down.
module pv_list #(
  parameter int MMAX = 96,
  parameter int VW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          remove,
  input  logic [VW-1:0] idx,
  output logic [VW-1:0] rd_data
);
  logic [VW-1:0] ent [MMAX];

  for (genvar g = 0; g < MMAX; g++) begin : g_ent
    if (g < MMAX - 1) begin : g_shift
      always_ff @(posedge clk) begin
        if (!rst_n || init)
          ent[g] <= VW'(g);
        else if (remove && (VW'(g) >= idx))
          ent[g] <= ent[g+1];
      end
    end else begin : g_top
      always_ff @(posedge clk) begin
        if (!rst_n || init)
          ent[g] <= VW'(g);
      end
    end
  end

  assign rd_data = (idx < VW'(MMAX)) ? ent[idx] : '0;
endmodule

// File: rtl/permvec_gen.sv
module permvec_gen
  import permvec_pkg::*;
#(
  parameter int MMAX = 96,
  parameter int SW   = 8,
  localparam int VW  = $clog2(MMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [VW-1:0] m_in,
  input  logic [SW-1:0] a_in,
  input  logic [SW-1:0] b_in,
  output logic          busy,
  output logic          err,
  output logic          done,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] out_index,
  output logic [VW-1:0] out_value
);
  localparam int NW = SW + VW + 1;

  pv_state_t     st;
  logic [VW-1:0] m_r;
  logic [SW-1:0] a_r;
  logic [VW-1:0] j_r;
  logic [NW-1:0] num_r;
  logic [VW-1:0] k_r;
  logic [VW-1:0] den;
  logic [VW-1:0] rem;
  logic [VW-1:0] pick;
  logic          fin;
  logic          take;
  logic          m_ok;
  logic          init;
  logic          xfer;

  assign take = start && ((st == ST_IDLE) || (st == ST_DONE));
  assign m_ok = (m_in != '0) && (m_in <= VW'(MMAX));
  assign init = take && m_ok;
  assign xfer = (st == ST_EMIT) && out_ready;
  assign den  = m_r + VW'(1) - j_r;

  pv_modred #(.NW(NW), .VW(VW)) u_mod (
    .clk(clk), .rst_n(rst_n), .go(st == ST_DIV_GO),
    .num(num_r), .den(den), .fin(fin), .rem(rem)
  );

  pv_list #(.MMAX(MMAX), .VW(VW)) u_list (
    .clk(clk), .rst_n(rst_n), .init(init), .remove(xfer),
    .idx(k_r), .rd_data(pick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      m_r   <= '0;
      a_r   <= '0;
      j_r   <= '0;
      num_r <= '0;
      k_r   <= '0;
      err   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE, ST_DONE: begin
          if (take) begin
            if (m_ok) begin
              err   <= 1'b0;
              m_r   <= m_in;
              a_r   <= a_in;
              j_r   <= VW'(1);
              num_r <= NW'(a_in) + NW'(b_in);
              st    <= ST_DIV_GO;
            end else begin
              err <= 1'b1;
              st  <= ST_IDLE;
            end
          end
        end
        ST_DIV_GO: st <= ST_DIV_WAIT;
        ST_DIV_WAIT: begin
          if (fin) begin
            k_r <= rem;
            st  <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            if (j_r == m_r) begin
              st <= ST_DONE;
            end else begin
              j_r   <= j_r + VW'(1);
              num_r <= num_r + NW'(a_r);
              st    <= ST_DIV_GO;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE) && (st != ST_DONE);
  assign done      = (st == ST_DONE);
  assign out_valid = (st == ST_EMIT);
  assign out_index = j_r;
  assign out_value = m_r - pick;
endmodule

// File: rtl/permvec_gen_chk.sv
module permvec_gen_chk #(
  parameter int VW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          err,
  input logic          done,
  input logic          out_valid,
  input logic          out_ready,
  input logic [VW-1:0] out_index,
  input logic [VW-1:0] out_value,
  input logic [VW-1:0] m_r
);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_value) && $stable(out_index)));

  a_r8_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!out_valid && !done && !busy));

  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !out_valid));

  a_r4_value_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_value != '0) && (out_value <= m_r)));

  a_r5_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_index != '0) && (out_index <= m_r)));

  a_r2_one_per_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
endmodule

bind permvec_gen permvec_gen_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .done(done),
  .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index),
  .out_value(out_value), .m_r(m_r)
);

// File: tb/permvec_gen_bench.sv
module permvec_gen_bench;
  localparam int MMAX = 96;
  localparam int SW   = 8;
  localparam int VW   = $clog2(MMAX + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [VW-1:0] m_in = '0;
  logic [SW-1:0] a_in = '0;
  logic [SW-1:0] b_in = '0;
  logic          busy, err, done, out_valid;
  logic          out_ready = 1'b0;
  logic [VW-1:0] out_index, out_value;

  int total = 0;
  int bad = 0;
  int got [256];

  always #5 clk = ~clk;

  permvec_gen #(.MMAX(MMAX), .SW(SW)) u_permvec_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .m_in(m_in), .a_in(a_in),
    .b_in(b_in), .busy(busy), .err(err), .done(done), .out_valid(out_valid),
    .out_ready(out_ready), .out_index(out_index), .out_value(out_value)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input int m, input int a, input int b,
                          input bit bp, input bit glitch);
    int expv [257];
    int lst [256];
    bit seen [257];
    int cnt, cyc, pv, pi;
    bit pend;
    for (int i = 0; i < m; i++) lst[i] = i;
    for (int i = 0; i <= m; i++) seen[i] = 1'b0;
    for (int j = 1; j <= m; j++) begin
      int k;
      k = (a * j + b) % (m + 1 - j);
      expv[j] = m - lst[k];
      for (int n = k; n < m - j; n++) lst[n] = lst[n+1];
    end
    @(negedge clk);
    m_in = VW'(m); a_in = SW'(a); b_in = SW'(b); start = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    cnt = 0; cyc = 0; pend = 1'b0; pv = 0; pi = 0;
    while (!done && cyc < 20000) begin
      if (pend) begin
        chk(out_valid && out_value == VW'(pv) && out_index == VW'(pi),
            "R6", "held value", int'(out_value), pv);
      end
      out_ready = bp ? (((cyc * 5 + m + a) % 3) != 0) : 1'b1;
      if (glitch && cyc == 5) begin
        start = 1'b1; m_in = VW'(3); a_in = SW'(1); b_in = SW'(1);
      end else begin
        start = 1'b0;
      end
      if (out_valid) begin
        if (out_ready) begin
          chk(int'(out_index) == cnt + 1, "R5", "index order", int'(out_index), cnt + 1);
          chk(int'(out_value) == expv[cnt+1], glitch ? "R9" : "R2", "value",
              int'(out_value), expv[cnt+1]);
          chk(out_value >= 1 && int'(out_value) <= m && !seen[out_value],
              "R4", "distinct in range", int'(out_value), 0);
          if (out_value <= VW'(m)) seen[out_value] = 1'b1;
          if (cnt < 256) got[cnt] = int'(out_value);
          cnt++;
          pend = 1'b0;
        end else begin
          pend = 1'b1; pv = int'(out_value); pi = int'(out_index);
        end
      end else begin
        pend = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    out_ready = 1'b0;
    chk(cnt == m, "R7", "transfer count", cnt, m);
    chk(done && !busy && !out_valid && !err, "R7", "done state", int'(done), 1);
    repeat (2) @(negedge clk);
    chk(done && !out_valid, "R7", "done held", int'(done), 1);
  endtask

  task automatic bad_case(input int m);
    @(negedge clk);
    m_in = VW'(m); a_in = SW'(1); b_in = SW'(2); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1, "R8", "err raised", int'(err), 1);
    for (int i = 0; i < 30; i++) begin
      if (out_valid || busy || done) begin
        chk(1'b0, "R8", "silent after reject", int'(out_valid), 0);
        break;
      end
      @(negedge clk);
    end
    chk(!out_valid && !busy && !done && err, "R8", "reject state", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !busy && !done && !err, "R1", "reset outputs",
        int'({out_valid, busy, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !busy && !done && !err, "R1", "idle after reset",
        int'({out_valid, busy, done, err}), 0);

    // R3: worked example
    run_case(6, 5, 3, 1'b0, 1'b0);
    chk(got[0] == 4 && got[1] == 2 && got[2] == 3 && got[3] == 1 && got[4] == 6 && got[5] == 5,
        "R3", "example sequence", got[0], 4);

    // R10: length one
    run_case(1, 7, 9, 1'b1, 1'b0);
    chk(got[0] == 1, "R10", "single value", got[0], 1);

    // R9: start while busy is ignored
    run_case(6, 5, 3, 1'b1, 1'b1);

    // R8: rejected sizes, then recovery
    bad_case(0);
    bad_case(MMAX + 1);
    bad_case(127);
    run_case(4, 2, 1, 1'b0, 1'b0);
    chk(!err, "R8", "err cleared", int'(err), 0);

    // R2/R4/R6 sweep
    for (int m = 1; m <= 10; m++)
      for (int a = 0; a <= 5; a++)
        for (int b = 0; b <= 5; b++)
          run_case(m, a, b, ((a + b) % 2) == 1, 1'b0);

    // size 83 seed pairs
    run_case(83, 5, 8, 1'b0, 1'b0);
    run_case(83, 2, 48, 1'b1, 1'b0);
    run_case(83, 7, 51, 1'b0, 1'b0);
    run_case(83, 3, 30, 1'b0, 1'b0);
    run_case(83, 3, 23, 1'b1, 1'b0);
    run_case(83, 17, 16, 1'b0, 1'b0);
    run_case(83, 9, 8, 1'b0, 1'b0);

    // R11: full size, largest seeds
    run_case(MMAX, 255, 255, 1'b1, 1'b0);
    chk(got[MMAX-1] >= 1, "R11", "full size last value", got[MMAX-1], 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule